// File: doc/BRIEF.md
# Half-Width Trap Condition Evaluator

This unit decides whether a compare-against-immediate trap instruction fires. It takes a register operand and a 16-bit signed immediate. A 2-bit select sets the register width at run time to 64, 32, 16 or 8 bits. The unit keeps only the least significant half of the register at that width and sign-extends it. This is 32 bits for a 64-bit register and 4 bits for an 8-bit register. It then compares the result with the sign-extended immediate.

A 5-bit condition mask chooses which relations count. Signed less-than, signed greater-than, equality, unsigned less-than and unsigned greater-than each have a mask bit. The trap flag is raised when any selected relation holds. The result is captured in one register stage and appears one clock after an input strobe. Instruction decode, exception dispatch and register reads belong to the surrounding pipeline.

Top module: `half_trap_eval`

## Requirements
- R1: `width_sel` picks the compared half: 00 uses `reg_op[31:0]`, 01 uses `reg_op[15:0]`, 10 uses `reg_op[7:0]`, 11 uses `reg_op[3:0]`. Bits of `reg_op` above that half do not affect `out_trap`.
- R2: The selected half is sign-extended from its own top bit before any comparison, so the nibble 4'hF compares equal to an immediate of -1.
- R3: `imm` is read as a 16-bit two's-complement value and is sign-extended before comparison, even when the operand half is narrower than 16 bits.
- R4: `cond_mask[0]` traps when the operand is signed-less-than the immediate.
- R5: `cond_mask[1]` traps when the operand is signed-greater-than the immediate.
- R6: `cond_mask[2]` traps when the operand equals the immediate.
- R7: `cond_mask[3]` traps on unsigned less-than and `cond_mask[4]` traps on unsigned greater-than. Both read the two sign-extended values as unsigned numbers of a common width.
- R8: `out_trap` is the OR of every selected relation that holds. A mask of 5'b00000 never traps and a mask of 5'b11111 always traps.
- R9: `out_valid` equals `in_valid` delayed by one clock. `out_trap` shows the result for the input captured at that edge. It holds its value across cycles with `in_valid` low.
- R10: Synchronous reset `rst` clears `out_valid` and `out_trap` at the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands present this cycle |
| reg_op | input | 64 | Register operand at full storage width |
| imm | input | 16 | Signed immediate |
| cond_mask | input | 5 | Relation enable bits |
| width_sel | input | 2 | Register width select (00=64, 01=32, 10=16, 11=8) |
| out_valid | output | 1 | Result strobe, one cycle after in_valid |
| out_trap | output | 1 | Trap decision |

## Verification
Each result is due exactly one rising edge after the edge that samples `in_valid` high. At that same edge `out_valid` must follow `in_valid`, and `out_trap` must hold whenever no new input was taken. The bench advances its reference model at every rising edge using the input values seen there. It compares both outputs one time unit later, so every check sees the register stage's settled output for that edge. Reset cycles are modelled the same way: the model's valid and trap are cleared at the first edge with `rst` high.

// File: rtl/trapw_pkg.sv
package trapw_pkg;

   // Runtime register-width select encoding
   typedef enum logic [1:0] {
      WSEL_64 = 2'b00,
      WSEL_32 = 2'b01,
      WSEL_16 = 2'b10,
      WSEL_8  = 2'b11
   } wsel_e;

   localparam int NUM_WSEL = 4;
   localparam int SEL_W    = $clog2(NUM_WSEL);

   // Positions of the relation flags in the relation vector
   localparam int REL_SLT = 0;
   localparam int REL_SGT = 1;
   localparam int REL_EQ  = 2;
   localparam int REL_ULT = 3;
   localparam int REL_UGT = 4;
   localparam int REL_N   = 5;

   function automatic int imax(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/trapw_half_ext.sv
module trapw_half_ext
   import trapw_pkg::*;
#(
   parameter int XLEN_MAX = 64,
   parameter int CMP_W    = 64
) (
   input  logic [XLEN_MAX-1:0] reg_i,
   input  logic [SEL_W-1:0]    sel_i,
   output logic [CMP_W-1:0]    half_o
);

   logic [CMP_W-1:0] cand [NUM_WSEL];

   // One candidate per selectable width: low half, sign-extended to CMP_W
   for (genvar g = 0; g < NUM_WSEL; g++) begin : g_width
      localparam int HW = (XLEN_MAX >> g) / 2;
      if (HW < 1 || HW >= CMP_W) begin : g_bad
         $error("trapw_half_ext: half width %0d out of range", HW);
      end
      assign cand[g] = {{(CMP_W-HW){reg_i[HW-1]}}, reg_i[HW-1:0]};
   end

   assign half_o = cand[sel_i];

endmodule

// File: rtl/trapw_rel.sv
module trapw_rel
   import trapw_pkg::*;
#(
   parameter int CMP_W      = 64,
   parameter int IMM_W      = 16,
   parameter bit SHARED_SUB = 1'b1
) (
   input  logic [CMP_W-1:0] a_i,
   input  logic [IMM_W-1:0] imm_i,
   output logic [REL_N-1:0] rel_o
);

   logic [CMP_W-1:0] b;
   logic slt, sgt, eq, ult, ugt;

   if (IMM_W > CMP_W) begin : g_bad
      $error("trapw_rel: immediate wider than compare width");
   end

   assign b  = {{(CMP_W-IMM_W){imm_i[IMM_W-1]}}, imm_i};
   assign eq = (a_i == b);

   if (SHARED_SUB) begin : g_sub
      // One subtractor; borrow gives unsigned order, sign fix-up gives signed
      logic [CMP_W:0] diff;
      logic           sgn_differ;
      assign diff       = {1'b0, a_i} - {1'b0, b};
      assign ult        = diff[CMP_W];
      assign sgn_differ = a_i[CMP_W-1] ^ b[CMP_W-1];
      assign slt        = sgn_differ ? a_i[CMP_W-1] : ult;
      assign ugt        = ~ult & ~eq;
      assign sgt        = ~slt & ~eq;
   end else begin : g_direct
      // Four independent magnitude comparators
      assign ult = (a_i < b);
      assign ugt = (a_i > b);
      assign slt = ($signed(a_i) < $signed(b));
      assign sgt = ($signed(a_i) > $signed(b));
   end

   always_comb begin
      rel_o          = '0;
      rel_o[REL_SLT] = slt;
      rel_o[REL_SGT] = sgt;
      rel_o[REL_EQ]  = eq;
      rel_o[REL_ULT] = ult;
      rel_o[REL_UGT] = ugt;
   end

endmodule

// File: rtl/half_trap_eval.sv
module half_trap_eval
   import trapw_pkg::*;
#(
   parameter int XLEN_MAX   = 64,
   parameter int IMM_W      = 16,
   parameter int MASK_W     = 5,
   parameter bit SHARED_SUB = 1'b1
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                in_valid,
   input  logic [XLEN_MAX-1:0] reg_op,
   input  logic [IMM_W-1:0]    imm,
   input  logic [MASK_W-1:0]   cond_mask,
   input  logic [SEL_W-1:0]    width_sel,
   output logic                out_valid,
   output logic                out_trap
);

   localparam int CMP_W = imax(IMM_W, XLEN_MAX);

   if (MASK_W != REL_N) begin : g_bad_mask
      $error("half_trap_eval: MASK_W must equal %0d", REL_N);
   end
   if ((XLEN_MAX >> (NUM_WSEL-1)) < 2) begin : g_bad_xlen
      $error("half_trap_eval: XLEN_MAX too small for narrowest width");
   end

   logic [CMP_W-1:0]  half_x;
   logic [REL_N-1:0]  rel_w;
   logic              trap_d;

   trapw_half_ext #(
      .XLEN_MAX (XLEN_MAX),
      .CMP_W    (CMP_W)
   ) u_ext (
      .reg_i  (reg_op),
      .sel_i  (width_sel),
      .half_o (half_x)
   );

   trapw_rel #(
      .CMP_W      (CMP_W),
      .IMM_W      (IMM_W),
      .SHARED_SUB (SHARED_SUB)
   ) u_rel (
      .a_i   (half_x),
      .imm_i (imm),
      .rel_o (rel_w)
   );

   assign trap_d = |(rel_w & cond_mask);

   always_ff @(posedge clk) begin
      if (rst) begin
         out_valid <= 1'b0;
         out_trap  <= 1'b0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            out_trap <= trap_d;
         end
      end
   end

endmodule

// File: rtl/trapw_chk.sv
module trapw_chk
   import trapw_pkg::*;
#(
   parameter int MASK_W = 5
) (
   input logic              clk,
   input logic              rst,
   input logic              in_valid,
   input logic [MASK_W-1:0] cond_mask,
   input logic [REL_N-1:0]  rel,
   input logic              out_valid,
   input logic              out_trap
);

   assert_valid_follow_R9: assert property (@(posedge clk) disable iff (rst)
      in_valid |=> out_valid);

   assert_valid_idle_R9: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> !out_valid);

   assert_trap_hold_R9: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> $stable(out_trap));

   assert_zero_mask_R8: assert property (@(posedge clk) disable iff (rst)
      (in_valid && cond_mask == '0) |=> !out_trap);

   assert_full_mask_R8: assert property (@(posedge clk) disable iff (rst)
      (in_valid && (&cond_mask)) |=> out_trap);

   assert_signed_order_R6: assert property (@(posedge clk) disable iff (rst)
      in_valid |-> $onehot({rel[REL_SLT], rel[REL_SGT], rel[REL_EQ]}));

   assert_unsigned_order_R7: assert property (@(posedge clk) disable iff (rst)
      in_valid |-> $onehot({rel[REL_ULT], rel[REL_UGT], rel[REL_EQ]}));

   assert_reset_clear_R10: assert property (@(posedge clk)
      rst |=> (!out_valid && !out_trap));

endmodule

bind half_trap_eval trapw_chk #(.MASK_W(MASK_W)) u_chk (
   .clk       (clk),
   .rst       (rst),
   .in_valid  (in_valid),
   .cond_mask (cond_mask),
   .rel       (rel_w),
   .out_valid (out_valid),
   .out_trap  (out_trap)
);

// File: tb/tb_half_trap_eval.sv
module tb_half_trap_eval;

   localparam time CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        in_valid = 1'b0;
   logic [63:0] reg_op = '0;
   logic [15:0] imm = '0;
   logic [4:0]  cond_mask = '0;
   logic [1:0]  width_sel = '0;
   logic        out_valid;
   logic        out_trap;

   int    n_checks = 0;
   int    n_errors = 0;
   bit    finished = 1'b0;
   string cur_tag  = "R9";

   bit    m_valid = 1'b0;
   bit    m_trap  = 1'b0;
   string m_tag   = "R10";

   always #(CLK_PERIOD/2) clk = ~clk;

   half_trap_eval dut (
      .clk       (clk),
      .rst       (rst),
      .in_valid  (in_valid),
      .reg_op    (reg_op),
      .imm       (imm),
      .cond_mask (cond_mask),
      .width_sel (width_sel),
      .out_valid (out_valid),
      .out_trap  (out_trap)
   );

   // Behavioural reference: half of selected width, signed/unsigned relations
   function automatic bit ref_trap(input logic [63:0] r, input logic [15:0] im,
                                   input logic [4:0] m, input logic [1:0] s);
      int               hw = 32 >> s;
      longint           a  = longint'(r << (64 - hw)) >>> (64 - hw);
      longint           b  = longint'($signed(im));
      longint unsigned  ua = a;
      longint unsigned  ub = b;
      return (m[0] && a < b) || (m[1] && a > b) || (m[2] && a == b) ||
             (m[3] && ua < ub) || (m[4] && ua > ub);
   endfunction

   task automatic check(input string tag, input string what,
                        input logic act, input logic exp);
      n_checks++;
      if (act !== exp) begin
         n_errors++;
         $display("FAIL %s %s actual=%0b expected=%0b at %0t", tag, what, act, exp, $time);
      end
   endtask

   // Advance the model at each edge, compare after the edge settles
   always @(posedge clk) begin
      if (rst) begin
         m_valid = 1'b0;
         m_trap  = 1'b0;
         m_tag   = "R10";
      end else begin
         m_valid = in_valid;
         if (in_valid) begin
            m_trap = ref_trap(reg_op, imm, cond_mask, width_sel);
            m_tag  = cur_tag;
         end else begin
            m_tag  = "R9";
         end
      end
      #1;
      if (!finished) begin
         check(rst ? "R10" : "R9", "out_valid", out_valid, m_valid);
         check(m_tag, "out_trap", out_trap, m_trap);
      end
   end

   task automatic send(input string tag, input logic [63:0] r, input logic [15:0] im,
                       input logic [4:0] m, input logic [1:0] s);
      @(negedge clk);
      cur_tag   = tag;
      in_valid  = 1'b1;
      reg_op    = r;
      imm       = im;
      cond_mask = m;
      width_sel = s;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         in_valid = 1'b0;
         reg_op   = {$urandom, $urandom};
         cond_mask = 5'h1f;
      end
   endtask

   task automatic finish_run();
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      n_checks++;
      n_errors++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      // R10: reset state
      repeat (3) @(negedge clk);
      check("R10", "reset out_valid", out_valid, 1'b0);
      check("R10", "reset out_trap", out_trap, 1'b0);
      rst = 1'b0;

      // R1: half selection, upper bits ignored
      send("R1", 64'hFFFF_FFFF_FFFF_FFF3, 16'd3,      5'b00100, 2'b11);
      send("R1", 64'h1234_5678_0000_0005, 16'd5,      5'b00100, 2'b00);
      send("R1", 64'hABCD_0000_0000_0042, 16'h0042,   5'b00100, 2'b01);
      send("R1", 64'h7777_7777_7777_7710, 16'h0010,   5'b00100, 2'b10);
      // R2: sign extension of the half
      send("R2", 64'h0000_0000_0000_000F, 16'hFFFF,   5'b00100, 2'b11);
      send("R2", 64'h0000_0000_0000_0080, 16'hFF80,   5'b00100, 2'b10);
      send("R2", 64'h0000_0000_0000_0080, 16'hFF80,   5'b00011, 2'b10);
      send("R2", 64'h0000_0000_0000_8000, 16'd0,      5'b00001, 2'b01);
      // R3: immediate sign extension
      send("R3", 64'h0,                   16'h8000,   5'b00010, 2'b00);
      send("R3", 64'h0000_0000_0000_0007, 16'hFFF8,   5'b00010, 2'b11);
      // R4/R5/R6: signed relations
      send("R4", 64'h0000_0000_FFFF_FFFE, 16'd1,      5'b00001, 2'b00);
      send("R4", 64'h0000_0000_0000_0009, 16'd1,      5'b00001, 2'b00);
      send("R5", 64'h0000_0000_0000_0007, 16'hFFFF,   5'b00010, 2'b11);
      send("R5", 64'h0000_0000_0000_0008, 16'd0,      5'b00010, 2'b11);
      send("R6", 64'h0000_0000_0000_7FFF, 16'h7FFF,   5'b00100, 2'b01);
      send("R6", 64'h0000_0000_0000_7FFE, 16'h7FFF,   5'b00100, 2'b01);
      // R7: unsigned relations on sign-extended values
      send("R7", 64'h0000_0000_0000_0008, 16'd5,      5'b10000, 2'b11);
      send("R7", 64'h0000_0000_0000_0008, 16'd5,      5'b01000, 2'b11);
      send("R7", 64'h0000_0000_0000_0003, 16'hFFFF,   5'b01000, 2'b11);
      send("R7", 64'h0000_0000_8000_0000, 16'h8000,   5'b10000, 2'b00);
      // R8: mask extremes and OR
      send("R8", 64'h0123_4567_89AB_CDEF, 16'h1234,   5'b00000, 2'b00);
      send("R8", 64'h0123_4567_89AB_CDEF, 16'h1234,   5'b11111, 2'b00);
      send("R8", 64'h0000_0000_0000_0005, 16'd5,      5'b11011, 2'b11);
      send("R8", 64'h0000_0000_0000_0004, 16'd5,      5'b10101, 2'b11);
      // R9: gaps keep trap held
      send("R9", 64'h0, 16'd0, 5'b00100, 2'b10);
      idle(3);
      send("R9", 64'h0, 16'd1, 5'b00100, 2'b10);
      idle(2);
      // R10: reset while traffic flows
      send("R10", 64'h0, 16'd0, 5'b11111, 2'b00);
      @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      @(negedge clk);
      rst = 1'b0;
      // Random traffic, mixed widths and masks
      for (int i = 0; i < 3000; i++) begin
         if ($urandom_range(3) == 0) begin
            idle(1);
         end else begin
            send("R8", {$urandom, $urandom}, 16'($urandom),
                 5'($urandom), 2'($urandom));
         end
      end
      idle(2);
      finish_run();
   end

endmodule